// File: doc/BRIEF.md
# 8-bit ALU with Status Flag Register

This block is the arithmetic and logic unit of a small accumulator processor. It takes an accumulator value, a memory value, the present carry flag and the decimal-mode bit, and it gives an 8-bit result at once through combinational logic. It also gives the next values of the four status flags and a write mask. The mask shows which flags the chosen operation changes.

The block keeps its own four-bit flag register. When `exec` is high at a rising clock edge, each flag whose mask bit is set takes its next value, and every other flag keeps its old value. The surrounding core decodes instructions, moves data to and from memory, and runs the program counter. That core also decides whether `result` goes back to the accumulator or to memory. Unary operations (increment, decrement, shifts and rotates) work on input `a`.

Top module: `alu8_flags`

## Requirements
- R1: Operation code 0 (add) gives `a + m + c_in` modulo 256. C is the carry out of bit 7. V is set when the signed sum is above 127 or below -128. N is result bit 7. Z is set when the 8-bit result is zero. The mask is 4'b1111.
- R2: Operation code 1 (subtract) gives `a - m - (1 - c_in)` modulo 256. C is 1 when no borrow was needed, meaning the exact difference is not negative. V is set when the signed difference is outside -128..127. N and Z follow the result. The mask is 4'b1111.
- R3: When `dec` is 1 and parameter DECIMAL_EN is 1, codes 0 and 1 treat valid packed-BCD operands as two decimal digits. The result is the BCD form of the decimal sum or difference modulo 100, for example 0x55 + 0x27 gives 0x82. C marks a decimal carry past 99 on add, and no borrow on subtract. V keeps its binary meaning. N and Z follow the BCD result. When DECIMAL_EN is 0, `dec` has no effect.
- R4: Code 2 (compare) gives `a - m` modulo 256 whatever `c_in` is. C is 1 exactly when `a >= m` as unsigned numbers. N and Z follow the result. V is not written (mask 4'b1110).
- R5: Code 3 gives `a + 1` and code 4 gives `a - 1`, both modulo 256. Only N and Z are written (mask 4'b1100).
- R6: Code 5 (shift left) shifts a zero into bit 0 and sends bit 7 to C. Code 6 (logical shift right) shifts a zero into bit 7 and sends bit 0 to C. Both have mask 4'b1110.
- R7: Code 7 (rotate left) moves `c_in` into bit 0 and bit 7 to C. Code 8 (rotate right) moves `c_in` into bit 7 and bit 0 to C. Both have mask 4'b1110.
- R8: Codes 9, 10 and 11 give `a & m`, `a | m` and `a ^ m`. Only N and Z are written (mask 4'b1100).
- R9: Code 12 (bit test) returns `a` unchanged and writes N = m[7], V = m[6] and Z = ((a & m) == 0). C is not written (mask 4'b1101).
- R10: Code 13 returns `m & ~a` and code 14 returns `m | a`. Both write N = m[7], V = m[6] and Z = (result == 0), with mask 4'b1101.
- R11: The flag vectors are ordered {N, Z, C, V} from bit 3 down to bit 0. Reset clears `nzcv_q`. At a rising edge with `exec` high, masked flags load `nzcv_nxt` and the others hold. With `exec` low, nothing changes. Flags outside the mask appear in `nzcv_nxt` with their registered values.
- R12: Code 15 (no operation) returns `a` and writes no flag (mask 4'b0000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec | input | 1 | Commit the masked flags at the next rising edge |
| op | input | 4 | Operation code |
| a | input | 8 | Accumulator operand |
| m | input | 8 | Memory operand |
| c_in | input | 1 | Current carry flag |
| dec | input | 1 | Decimal mode for add and subtract |
| result | output | 8 | Operation result |
| nzcv_nxt | output | 4 | Next flag values {N,Z,C,V} |
| nzcv_we | output | 4 | Per-flag write mask {N,Z,C,V} |
| nzcv_q | output | 4 | Registered flags {N,Z,C,V} |

## Verification
The bench builds two copies of the block side by side with the same stimulus. `u0` has DECIMAL_EN = 1, so decimal add and subtract on valid BCD operands are exercised, including wrap past 99 and borrow below 00. `u1` has DECIMAL_EN = 0, so the same cycles with `dec` high must give pure binary results, which tests that the mode bit is ignored. Directed cases cover signed overflow, compare with the carry set both ways, and the rotates through carry. They also cover the hold of the flag register when `exec` is low.

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter bit DECIMAL_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exec,
  input  logic [3:0] op,
  input  logic [7:0] a,
  input  logic [7:0] m,
  input  logic       c_in,
  input  logic       dec,
  output logic [7:0] result,
  output logic [3:0] nzcv_nxt,
  output logic [3:0] nzcv_we,
  output logic [3:0] nzcv_q
);

  localparam logic [3:0] OP_ADD = 4'd0,  OP_SUB = 4'd1,  OP_CMP = 4'd2,  OP_INC = 4'd3;
  localparam logic [3:0] OP_DEC = 4'd4,  OP_SHL = 4'd5,  OP_SHR = 4'd6,  OP_RL  = 4'd7;
  localparam logic [3:0] OP_RR  = 4'd8,  OP_AND = 4'd9,  OP_OR  = 4'd10, OP_XOR = 4'd11;
  localparam logic [3:0] OP_TST = 4'd12, OP_CLR = 4'd13, OP_SET = 4'd14;

  logic       is_sub, dmode, cin_eff, bin_ov;
  logic [7:0] m_eff;
  logic [8:0] bsum;

  assign is_sub  = (op == OP_SUB) || (op == OP_CMP);
  assign dmode   = DECIMAL_EN && dec;
  assign m_eff   = is_sub ? ~m : m;
  assign cin_eff = (op == OP_CMP) ? 1'b1 : c_in;
  assign bsum    = {1'b0, a} + {1'b0, m_eff} + {8'd0, cin_eff};
  assign bin_ov  = (a[7] == m_eff[7]) && (bsum[7] != a[7]);

  logic [5:0] lo, hi;
  logic       lo_x, hi_x;
  logic [7:0] dres;
  logic       dcar;

  always_comb begin
    if (op == OP_SUB) begin
      lo   = {2'b0, a[3:0]} - {2'b0, m[3:0]} - {5'd0, ~c_in};
      lo_x = lo[5];
      if (lo_x) lo = lo - 6'd6;
      hi   = {2'b0, a[7:4]} - {2'b0, m[7:4]} - {5'd0, lo_x};
      hi_x = hi[5];
      if (hi_x) hi = hi - 6'd6;
      dcar = ~hi_x;
    end else begin
      lo   = {2'b0, a[3:0]} + {2'b0, m[3:0]} + {5'd0, c_in};
      lo_x = lo > 6'd9;
      if (lo_x) lo = lo + 6'd6;
      hi   = {2'b0, a[7:4]} + {2'b0, m[7:4]} + {5'd0, lo_x};
      hi_x = hi > 6'd9;
      if (hi_x) hi = hi + 6'd6;
      dcar = hi_x;
    end
    dres = {hi[3:0], lo[3:0]};
  end

  logic fn, fz, fc, fv;

  always_comb begin
    result  = a;
    nzcv_we = 4'b0000;
    fc      = nzcv_q[1];
    fv      = nzcv_q[0];
    case (op)
      OP_ADD, OP_SUB: begin
        result  = dmode ? dres : bsum[7:0];
        fc      = dmode ? dcar : bsum[8];
        fv      = bin_ov;
        nzcv_we = 4'b1111;
      end
      OP_CMP: begin result = bsum[7:0]; fc = bsum[8]; nzcv_we = 4'b1110; end
      OP_INC: begin result = a + 8'd1; nzcv_we = 4'b1100; end
      OP_DEC: begin result = a - 8'd1; nzcv_we = 4'b1100; end
      OP_SHL: begin result = {a[6:0], 1'b0}; fc = a[7]; nzcv_we = 4'b1110; end
      OP_SHR: begin result = {1'b0, a[7:1]}; fc = a[0]; nzcv_we = 4'b1110; end
      OP_RL:  begin result = {a[6:0], c_in}; fc = a[7]; nzcv_we = 4'b1110; end
      OP_RR:  begin result = {c_in, a[7:1]}; fc = a[0]; nzcv_we = 4'b1110; end
      OP_AND: begin result = a & m; nzcv_we = 4'b1100; end
      OP_OR:  begin result = a | m; nzcv_we = 4'b1100; end
      OP_XOR: begin result = a ^ m; nzcv_we = 4'b1100; end
      OP_TST: begin fv = m[6]; nzcv_we = 4'b1101; end
      OP_CLR: begin result = m & ~a; fv = m[6]; nzcv_we = 4'b1101; end
      OP_SET: begin result = m | a;  fv = m[6]; nzcv_we = 4'b1101; end
      default: ;
    endcase
    fn = nzcv_we[3] ? ((op >= OP_TST) ? m[7] : result[7]) : nzcv_q[3];
    fz = nzcv_we[2] ? ((op == OP_TST) ? ((a & m) == 8'd0) : (result == 8'd0)) : nzcv_q[2];
  end

  assign nzcv_nxt = {fn, fz, fc, fv};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    nzcv_q <= 4'b0000;
    else if (exec) nzcv_q <= (nzcv_we & nzcv_nxt) | (~nzcv_we & nzcv_q);

  // R4: compare carry matches an unsigned magnitude test, independent of c_in
  a_r4_cmp_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CMP) |-> (nzcv_nxt[1] == (a >= m)));

  // R3: valid BCD inputs give valid BCD digits on a decimal add
  a_r3_bcd_digits: assert property (@(posedge clk) disable iff (!rst_n)
    (dmode && op == OP_ADD && a[7:4] <= 4'd9 && a[3:0] <= 4'd9 && m[7:4] <= 4'd9 && m[3:0] <= 4'd9)
      |-> (result[7:4] <= 4'd9 && result[3:0] <= 4'd9));

  // R7: rotates carry the incoming flag into the vacated end
  a_r7_rotate_in: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_RL) |-> (result[0] == c_in));

  // R1: N and Z are never both set by an operation that judges the result
  a_r1_nz_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (op < OP_TST) |-> !(nzcv_nxt[3] && nzcv_nxt[2]));

  // R11: unmasked flags hold across a commit
  a_r11_hold_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !nzcv_we[1]) |=> (nzcv_q[1] == $past(nzcv_q[1])));

  // R11: without a commit the flag register stays put
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> $stable(nzcv_q));

endmodule

// File: tb/sim_alu8_flags.sv
module sim_alu8_flags;
  logic clk = 1'b0, rst_n = 1'b0, exec = 1'b0, c_in = 1'b0, dec = 1'b0;
  logic [3:0] op = 4'd15;
  logic [7:0] a = 8'd0, m = 8'd0;
  logic [7:0] r0, r1;
  logic [3:0] nx0, nx1, we0, we1, q0, q1;
  logic [3:0] q0e = 4'd0, q1e = 4'd0;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  alu8_flags #(.DECIMAL_EN(1'b1)) u0 (.clk(clk), .rst_n(rst_n), .exec(exec), .op(op), .a(a), .m(m),
    .c_in(c_in), .dec(dec), .result(r0), .nzcv_nxt(nx0), .nzcv_we(we0), .nzcv_q(q0));
  alu8_flags #(.DECIMAL_EN(1'b0)) u1 (.clk(clk), .rst_n(rst_n), .exec(exec), .op(op), .a(a), .m(m),
    .c_in(c_in), .dec(dec), .result(r1), .nzcv_nxt(nx1), .nzcv_we(we1), .nzcv_q(q1));

  function automatic int sx(input logic [7:0] x);
    return (x > 127) ? int'(x) - 256 : int'(x);
  endfunction
  function automatic int b2d(input logic [7:0] x);
    return x[7:4] * 10 + x[3:0];
  endfunction
  function automatic logic [7:0] d2b(input int v);
    logic [3:0] t, u;
    t = 4'(v / 10); u = 4'(v % 10);
    return {t, u};
  endfunction

  function automatic string tag(input logic [3:0] o, input logic d);
    case (o)
      0, 1: return d ? "R3" : (o == 0 ? "R1" : "R2");
      2: return "R4";   3, 4: return "R5";  5, 6: return "R6";
      7, 8: return "R7"; 9, 10, 11: return "R8"; 12: return "R9";
      13, 14: return "R10"; default: return "R12";
    endcase
  endfunction

  task automatic model(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y, input logic c,
                       input logic d, input logic [3:0] q,
                       output logic [7:0] r, output logic [3:0] f, output logic [3:0] w);
    int s, sa;
    logic n, z, cy, v;
    {n, z, cy, v} = q; r = x; w = 4'b0000;
    case (o)
      0: begin
        sa = sx(x) + sx(y) + c; v = (sa > 127) || (sa < -128); w = 4'b1111;
        if (d) begin s = b2d(x) + b2d(y) + c; cy = s > 99; r = d2b(s % 100); end
        else begin s = x + y + c; cy = s > 255; r = 8'(s); end
      end
      1: begin
        sa = sx(x) - sx(y) - (1 - c); v = (sa > 127) || (sa < -128); w = 4'b1111;
        if (d) begin s = b2d(x) - b2d(y) - (1 - c); cy = s >= 0; r = d2b((s + 100) % 100); end
        else begin s = x - y - (1 - c); cy = s >= 0; r = 8'(s); end
      end
      2: begin r = x - y; cy = x >= y; w = 4'b1110; end
      3: begin r = x + 1; w = 4'b1100; end
      4: begin r = x - 1; w = 4'b1100; end
      5: begin r = x * 2; cy = x >= 128; w = 4'b1110; end
      6: begin r = x / 2; cy = x % 2; w = 4'b1110; end
      7: begin r = x * 2 + c; cy = x >= 128; w = 4'b1110; end
      8: begin r = x / 2 + (c ? 128 : 0); cy = x % 2; w = 4'b1110; end
      9: begin r = x & y; w = 4'b1100; end
      10: begin r = x | y; w = 4'b1100; end
      11: begin r = x ^ y; w = 4'b1100; end
      12: begin r = x; w = 4'b1101; end
      13: begin r = y & ~x; w = 4'b1101; end
      14: begin r = y | x; w = 4'b1101; end
      default: ;
    endcase
    if (w[3]) n = (o >= 12) ? y[7] : r[7];
    if (w[2]) z = (o == 12) ? ((x & y) == 0) : (r == 0);
    if (o >= 12 && o <= 14) v = y[6];
    f = {n, z, cy, v};
  endtask

  task automatic chk(input string t, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                     input logic c, input logic d, input logic ex);
    logic [7:0] er0, er1;
    logic [3:0] ef0, ef1, ew0, ew1;
    string t0, t1;
    @(negedge clk);
    op = o; a = x; m = y; c_in = c; dec = d; exec = ex;
    #1;
    model(o, x, y, c, d, q0e, er0, ef0, ew0);
    model(o, x, y, c, 1'b0, q1e, er1, ef1, ew1);
    t0 = tag(o, d); t1 = (d && o <= 1) ? "R3" : tag(o, 1'b0);
    chk(t0, "result", r0, er0);
    chk(t0, "flags", nx0, ef0);
    chk(t0, "mask", we0, ew0);
    chk(t1, "result dec-off", r1, er1);
    chk(t1, "flags dec-off", nx1, ef1);
    @(posedge clk); #1;
    if (ex) begin q0e = ef0; q1e = ef1; end
    chk("R11", "flag reg", q0, q0e);
    chk("R11", "flag reg dec-off", q1, q1e);
  endtask

  initial begin
    #800000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    #9 rst_n = 1'b1;
    #1 chk("R11", "reset value", q0, 4'd0);
    // directed corners
    run(0, 8'h55, 8'h27, 0, 1, 1);   // R3 decimal example
    run(0, 8'h99, 8'h01, 0, 1, 1);   // R3 decimal wrap past 99
    run(1, 8'h00, 8'h01, 1, 1, 1);   // R3 decimal borrow below 00
    run(1, 8'h10, 8'h01, 1, 1, 1);   // R3
    run(0, 8'h7F, 8'h01, 0, 0, 1);   // R1 signed overflow
    run(0, 8'hFF, 8'h01, 0, 0, 1);   // R1 carry and zero
    run(1, 8'h80, 8'h01, 1, 0, 1);   // R2 overflow
    run(1, 8'h05, 8'h05, 0, 0, 1);   // R2 borrow in
    run(2, 8'h05, 8'h05, 0, 0, 1);   // R4 carry ignored
    run(2, 8'h02, 8'h85, 1, 0, 1);   // R4
    run(3, 8'hFF, 8'h00, 1, 0, 1);   // R5 wrap, C held
    run(4, 8'h00, 8'h00, 0, 0, 1);   // R5
    run(5, 8'h81, 8'h00, 0, 0, 1);   // R6
    run(6, 8'h01, 8'h00, 0, 0, 1);   // R6
    run(7, 8'h80, 8'h00, 1, 0, 1);   // R7
    run(8, 8'h01, 8'h00, 1, 0, 1);   // R7
    run(12, 8'h0F, 8'hC0, 0, 0, 1);  // R9
    run(13, 8'h0F, 8'hFF, 0, 0, 1);  // R10
    run(14, 8'h00, 8'h00, 0, 0, 1);  // R10
    run(15, 8'hA5, 8'h00, 1, 1, 1);  // R12
    run(0, 8'h7F, 8'h7F, 1, 0, 0);   // R11 no commit
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] o;
      logic [7:0] x, y;
      logic d;
      o = 4'($urandom_range(0, 15));
      d = 1'($urandom);
      x = 8'($urandom); y = 8'($urandom);
      if (d && o <= 1) begin
        x = d2b($urandom_range(0, 99)); y = d2b($urandom_range(0, 99));
      end
      run(o, x, y, 1'($urandom), d, ($urandom_range(0, 3) != 0));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule